// File: doc/BRIEF.md
# I2C Boot Configuration Loader

This block is a single-shot I2C master that runs once after reset. It pulls a fixed-length image of configuration bytes out of a small serial EEPROM and hands each byte, with its position in the image, to a register-write port. Both bus lines are open-drain. The block only ever pulls a line low through a drive-low enable, and it produces a logic 1 by letting go of the line. It reads both lines back through a two-flop synchroniser.

The transfer is a random-address sequential read. The master sends a Start, then the device address with the write direction, then the word address. It follows with a repeated Start, the device address with the read direction, and then clocks in the whole image. It acknowledges every byte except the last one, which it leaves unacknowledged, and then it sends a Stop. If the slave leaves any byte the master sends unacknowledged, the master stops the bus at once and raises a sticky error flag. The master does not retry.

The SCL period comes from the system clock. It is split into four equal quarters of `QTR = CLK_HZ / (4*BIT_HZ)` clocks each, and the defaults give 50 kbit/s from 100 MHz.

Top module: `i2c_boot_loader`

## Requirements
- R1: While `rst` is high, both drive-low outputs and `cfg_valid_o`, `done_o` and `error_o` are 0.
- R2: Start is SDA falling while SCL is high, and Stop is SDA rising while SCL is high. SDA changes at no other time while SCL is high, so a complete load shows exactly two Starts (the initial one and the repeated one) and one Stop.
- R3: Bytes are sent most significant bit first. The first byte is `{DEV_ADDR, 0}` (0xA0 for address 0x50), the second is `WORD_ADDR` (0x00), and the first byte after the repeated Start is `{DEV_ADDR, 1}` (0xA1).
- R4: The interval between successive SCL rising edges is always exactly `4*QTR` system clocks.
- R5: In the ninth clock of each data byte, the master pulls SDA low for every byte except the last. For the last byte it leaves SDA released and then issues Stop.
- R6: Each received byte appears on `cfg_data_o` with `cfg_valid_o` high for exactly one clock. `cfg_index_o` counts 0, 1, ..., `NUM_BYTES-1` in order.
- R7: `done_o` rises only after the final Stop of a successful load and stays high until reset. `error_o` stays low in that case.
- R8: The master treats an acknowledge as missing when, at the middle of the ninth clock's high phase, the sampled SDA is high or the sampled SCL is low. A missing acknowledge on any byte the master sends (either address byte or the word address) makes the master issue Stop in the next bit time and set `error_o`, which is held until reset. In that case `done_o` stays low and no byte is delivered.
- R9: Once `done_o` or `error_o` is set, both lines stay released and no further byte is delivered until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; a load starts when it falls |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_data_o | output | 8 | Received configuration byte |
| cfg_index_o | output | IDX_W | Position of the byte in the image |
| cfg_valid_o | output | 1 | One-clock strobe qualifying data and index |
| done_o | output | 1 | Load finished with a Stop, sticky |
| error_o | output | 1 | Load abandoned on a missing acknowledge, sticky |

## Verification
Line drives follow the sequencer by one register stage. The synchroniser adds two more clocks, so the acknowledge sample lands `QTR` clocks after the quarter begins, and this needs `QTR >= 4`. No result has a fixed latency from reset, so the bench recomputes bus timing on every SCL rising edge against `4*QTR`. It checks every byte strobe on the falling clock edge at which it is high, comparing it against an arithmetic image and the expected index, and it confirms the strobe is low on the next sample. Terminal flags are awaited with a bounded wait and then compared with the slave model's record of Starts, Stops, received bytes and master acknowledges. A hold window of 60 clocks afterwards confirms that nothing moves.

// File: rtl/i2c_boot_pkg.sv
package i2c_boot_pkg;

  typedef enum logic [1:0] {
    BK_START,
    BK_STOP,
    BK_WR,
    BK_RD
  } bit_kind_e;

  typedef enum logic [3:0] {
    ST_BEGIN,
    ST_DEVW,
    ST_WORD,
    ST_RSTART,
    ST_DEVR,
    ST_DATA,
    ST_STOP,
    ST_ABORT,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } line_drv_t;

  // Quarter 0: SCL goes low, SDA held. Quarter 1: SDA takes its new value.
  // Quarters 2 and 3: SCL released; Start/Stop move SDA entering quarter 3.
  function automatic line_drv_t quarter_drive(bit_kind_e kind, logic [1:0] q,
                                              logic wbit, logic sda_prev);
    line_drv_t d;
    d.scl_low = (q < 2'd2);
    d.sda_low = sda_prev;
    if (q != 2'd0) begin
      case (kind)
        BK_START: d.sda_low = (q == 2'd3);
        BK_STOP:  d.sda_low = (q != 2'd3);
        BK_WR:    d.sda_low = ~wbit;
        default:  d.sda_low = 1'b0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/i2c_boot_tick.sv
module i2c_boot_tick #(
  parameter int QTR = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == LAST) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/i2c_boot_sync.sv
module i2c_boot_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= '1;
      sync_o <= '1;
    end else begin
      meta   <= async_i;
      sync_o <= meta;
    end
  end
endmodule

// File: rtl/i2c_boot_lines.sv
module i2c_boot_lines
  import i2c_boot_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      active_i,
  input  bit_kind_e kind_i,
  input  logic [1:0] quarter_i,
  input  logic      wbit_i,
  output logic      scl_low_o,
  output logic      sda_low_o
);
  line_drv_t nxt;

  always_comb begin
    nxt = quarter_drive(kind_i, quarter_i, wbit_i, sda_low_o);
    if (!active_i) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      scl_low_o <= nxt.scl_low;
      sda_low_o <= nxt.sda_low;
    end
  end

  // R2: SDA is pulled low under a released SCL only as part of a Start bit
  assert_start_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!scl_low_o && !$past(scl_low_o) && $rose(sda_low_o)) |-> ($past(kind_i) == BK_START));

  // R2: SDA is let go under a released SCL only as part of a Stop bit
  assert_stop_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (!scl_low_o && !$past(scl_low_o) && $fell(sda_low_o)) |-> ($past(kind_i) == BK_STOP));
endmodule

// File: rtl/i2c_boot_seq.sv
module i2c_boot_seq
  import i2c_boot_pkg::*;
#(
  parameter int         NUM_BYTES = 16,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] WORD_ADDR = 8'h00,
  parameter int         IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             scl_s,
  input  logic             sda_s,
  output bit_kind_e        kind_o,
  output logic [1:0]       quarter_o,
  output logic             wbit_o,
  output logic             active_o,
  output logic [7:0]       data_o,
  output logic [IDX_W-1:0] index_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             error_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  seq_state_e       state;
  logic [3:0]       bcnt;
  logic [1:0]       q;
  logic [7:0]       shreg;
  logic [7:0]       tx_byte;
  logic             nack;
  logic [IDX_W-1:0] idx;
  logic             bit_last;

  assign bit_last  = (bcnt == 4'd8);
  assign quarter_o = q;
  assign active_o  = (state != ST_DONE) && (state != ST_FAIL);

  always_comb begin
    tx_byte = 8'h00;
    kind_o  = BK_STOP;
    wbit_o  = 1'b1;
    case (state)
      ST_BEGIN, ST_RSTART: kind_o = BK_START;
      ST_DEVW, ST_WORD, ST_DEVR: begin
        if (state == ST_DEVW)      tx_byte = {DEV_ADDR, 1'b0};
        else if (state == ST_WORD) tx_byte = WORD_ADDR;
        else                       tx_byte = {DEV_ADDR, 1'b1};
        kind_o = bit_last ? BK_RD : BK_WR;
        wbit_o = tx_byte[~bcnt[2:0]];
      end
      ST_DATA: begin
        kind_o = bit_last ? BK_WR : BK_RD;
        wbit_o = (idx == LAST_IDX);
      end
      default: kind_o = BK_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    valid_o <= 1'b0;
    if (rst) begin
      state   <= ST_BEGIN;
      q       <= 2'd0;
      bcnt    <= 4'd0;
      shreg   <= 8'h00;
      nack    <= 1'b0;
      idx     <= '0;
      data_o  <= 8'h00;
      index_o <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else if (tick && active_o) begin
      q <= q + 2'd1;
      if (q == 2'd2) begin
        nack <= sda_s | ~scl_s;
        if (state == ST_DATA && !bit_last) shreg <= {shreg[6:0], sda_s};
      end
      if (q == 2'd3) begin
        case (state)
          ST_BEGIN:  state <= ST_DEVW;
          ST_RSTART: state <= ST_DEVR;
          ST_DEVW, ST_WORD, ST_DEVR: begin
            if (bit_last) begin
              bcnt <= 4'd0;
              if (nack)                  state <= ST_ABORT;
              else if (state == ST_DEVW) state <= ST_WORD;
              else if (state == ST_WORD) state <= ST_RSTART;
              else                       state <= ST_DATA;
            end else begin
              bcnt <= bcnt + 4'd1;
            end
          end
          ST_DATA: begin
            if (bit_last) begin
              bcnt <= 4'd0;
              if (idx == LAST_IDX) state <= ST_STOP;
              else                 idx   <= idx + IDX_W'(1);
            end else begin
              bcnt <= bcnt + 4'd1;
              if (bcnt == 4'd7) begin
                valid_o <= 1'b1;
                data_o  <= shreg;
                index_o <= idx;
              end
            end
          end
          ST_STOP: begin
            state  <= ST_DONE;
            done_o <= 1'b1;
          end
          ST_ABORT: begin
            state   <= ST_FAIL;
            error_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  assert_error_hold_R8: assert property (@(posedge clk) disable iff (rst)
    error_o |=> error_o);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_index_range_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (index_o <= LAST_IDX));

  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o || error_o) |-> !valid_o);
endmodule

// File: rtl/i2c_boot_loader.sv
module i2c_boot_loader
  import i2c_boot_pkg::*;
#(
  parameter int         CLK_HZ    = 100_000_000,
  parameter int         BIT_HZ    = 50_000,
  parameter int         NUM_BYTES = 16,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] WORD_ADDR = 8'h00,
  parameter int         QTR       = CLK_HZ / (4 * BIT_HZ),
  parameter int         IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_drive_low_o,
  output logic [7:0]       cfg_data_o,
  output logic [IDX_W-1:0] cfg_index_o,
  output logic             cfg_valid_o,
  output logic             done_o,
  output logic             error_o
);
  logic       tick;
  logic [1:0] line_s;
  bit_kind_e  kind;
  logic [1:0] quarter;
  logic       wbit;
  logic       active;

  i2c_boot_tick #(.QTR(QTR)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  i2c_boot_sync #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_s)
  );

  i2c_boot_seq #(
    .NUM_BYTES (NUM_BYTES),
    .DEV_ADDR  (DEV_ADDR),
    .WORD_ADDR (WORD_ADDR),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .scl_s     (line_s[1]),
    .sda_s     (line_s[0]),
    .kind_o    (kind),
    .quarter_o (quarter),
    .wbit_o    (wbit),
    .active_o  (active),
    .data_o    (cfg_data_o),
    .index_o   (cfg_index_o),
    .valid_o   (cfg_valid_o),
    .done_o    (done_o),
    .error_o   (error_o)
  );

  i2c_boot_lines u_lines (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .kind_i    (kind),
    .quarter_i (quarter),
    .wbit_i    (wbit),
    .scl_low_o (scl_drive_low_o),
    .sda_low_o (sda_drive_low_o)
  );

  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o || error_o) |-> (!scl_drive_low_o && !sda_drive_low_o));
endmodule

// File: tb/i2c_boot_loader_test.sv
module i2c_boot_loader_test;
  localparam int         N   = 5;
  localparam int         QTR = 5;
  localparam int         PER = 4 * QTR;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       m_scl_low, m_sda_low, s_low;
  logic       scl_bus, sda_bus;
  logic [7:0] cfg_data;
  logic [2:0] cfg_index;
  logic       cfg_valid, done, error;

  assign scl_bus = ~m_scl_low;
  assign sda_bus = ~(m_sda_low | s_low);

  i2c_boot_loader #(
    .CLK_HZ(1_000_000), .BIT_HZ(50_000), .NUM_BYTES(N), .DEV_ADDR(DEV)
  ) uut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_drive_low_o(m_scl_low), .sda_drive_low_o(m_sda_low),
    .cfg_data_o(cfg_data), .cfg_index_o(cfg_index), .cfg_valid_o(cfg_valid),
    .done_o(done), .error_o(error)
  );

  int checks = 0, fails = 0;
  int sel = 0, seed_mul = 37, seed_add = 11;

  function automatic logic [7:0] memv(int i);
    return 8'(i * seed_mul + seed_add);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // EEPROM slave model and bus monitor
  logic       pscl, psda, gave, macked, s_dir;
  int         mode, cnt, bytes, ptr, rx_n, starts, stops, bad_int;
  int         macks, mnacks, nack_at, cyc, last_rise;
  bit         have_rise;
  logic [7:0] sh, tx, cur_b, nxt_b;
  logic [7:0] rxlog [4];
  logic       ack_ok;

  always_comb begin
    cur_b  = memv(ptr);
    nxt_b  = memv(ptr + 1);
    ack_ok = !((bytes == 0 && sh[7:1] != DEV) ||
               (sel == 1 && bytes == 0 && !sh[0]) ||
               (sel == 2 && bytes == 1 && !s_dir) ||
               (sel == 3 && bytes == 0 && sh[0]));
  end

  always @(posedge clk) begin
    pscl <= scl_bus;
    psda <= sda_bus;
    cyc  <= cyc + 1;
    if (rst) begin
      pscl <= 1'b1; psda <= 1'b1; s_low <= 1'b0; gave <= 1'b0; macked <= 1'b0;
      s_dir <= 1'b0; mode <= 0; cnt <= 0; bytes <= 0; ptr <= 0; rx_n <= 0;
      starts <= 0; stops <= 0; bad_int <= 0; macks <= 0; mnacks <= 0;
      nack_at <= -1; have_rise <= 1'b0; last_rise <= 0; sh <= 8'h00; tx <= 8'h00;
      for (int i = 0; i < 4; i++) rxlog[i] <= 8'hxx;
    end else begin
      if (scl_bus && !pscl) begin
        if (have_rise && (cyc - last_rise) != PER) bad_int <= bad_int + 1;
        have_rise <= 1'b1;
        last_rise <= cyc;
      end
      if (scl_bus && pscl && psda && !sda_bus) begin
        starts <= starts + 1; mode <= 1; cnt <= 0; bytes <= 0; s_low <= 1'b0;
      end else if (scl_bus && pscl && !psda && sda_bus) begin
        stops <= stops + 1; mode <= 0; s_low <= 1'b0;
      end else if (scl_bus && !pscl && mode != 0) begin
        if (mode == 1 && cnt < 8) sh <= {sh[6:0], sda_bus};
        if (mode == 2 && cnt == 8) macked <= !sda_bus;
        cnt <= cnt + 1;
      end else if (!scl_bus && pscl && mode != 0) begin
        if (cnt == 9) begin
          cnt <= 0;
          if (mode == 1) begin
            if (!gave) begin
              mode <= 0; s_low <= 1'b0;
            end else begin
              if (rx_n < 4) rxlog[rx_n] <= sh;
              rx_n  <= rx_n + 1;
              bytes <= bytes + 1;
              if (bytes == 0) s_dir <= sh[0];
              if (bytes == 0 && sh[0]) begin
                mode <= 2; tx <= cur_b; s_low <= !cur_b[7];
              end else begin
                s_low <= 1'b0;
                if (bytes == 1 && !s_dir) ptr <= int'(sh);
              end
            end
          end else begin
            if (macked) begin
              macks <= macks + 1; ptr <= ptr + 1; tx <= nxt_b; s_low <= !nxt_b[7];
            end else begin
              mnacks <= mnacks + 1; nack_at <= ptr; mode <= 0; s_low <= 1'b0;
            end
          end
        end else if (mode == 1) begin
          if (cnt == 8) begin s_low <= ack_ok; gave <= ack_ok; end
          else s_low <= 1'b0;
        end else begin
          if (cnt < 8) s_low <= !tx[7 - cnt];
          else         s_low <= 1'b0;
        end
      end
    end
  end

  // Strobe monitor (R6)
  int vcount;
  bit prev_v;
  always @(negedge clk) begin
    if (rst) begin
      vcount = 0; prev_v = 1'b0;
    end else begin
      if (cfg_valid) begin
        chk(!prev_v, "R6 strobe one clock", 1, 0);
        chk(int'(cfg_index) == vcount, "R6 index order", int'(cfg_index), vcount);
        chk(cfg_data == memv(vcount), "R6 byte value", cfg_data, memv(vcount));
        vcount++;
      end
      prev_v = cfg_valid;
    end
  end

  task automatic run(input int s, input int mul, input int add);
    int  t;
    bit  seen_done;
    sel = s; seed_mul = mul; seed_add = add;
    @(negedge clk); rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!m_scl_low && !m_sda_low, "R1 lines released in reset", {m_scl_low, m_sda_low}, 0);
    chk(!cfg_valid && !done && !error, "R1 flags low in reset", {cfg_valid, done, error}, 0);
    rst = 1'b0;
    t = 0; seen_done = 1'b0;
    while (!done && !error && t < 6000) begin
      @(negedge clk); t++;
    end
    chk(t < 6000, "R7 load ended", t, 6000);
    seen_done = done;
    chk(bad_int == 0, "R4 SCL period", bad_int, 0);
    chk(stops == 1, "R2 one Stop before flag", stops, 1);
    if (s == 0) begin
      chk(done && !error, "R7 done without error", {done, error}, 2);
      chk(starts == 2, "R2 Start plus repeated Start", starts, 2);
      chk(vcount == N, "R6 byte count", vcount, N);
      chk(rx_n == 3, "R3 bytes accepted by slave", rx_n, 3);
      chk(rxlog[0] == {DEV, 1'b0}, "R3 write address byte", rxlog[0], {DEV, 1'b0});
      chk(rxlog[1] == 8'h00, "R3 word address byte", rxlog[1], 0);
      chk(rxlog[2] == {DEV, 1'b1}, "R3 read address byte", rxlog[2], {DEV, 1'b1});
      chk(macks == N - 1, "R5 acknowledged data bytes", macks, N - 1);
      chk(mnacks == 1 && nack_at == N - 1, "R5 last byte left unacknowledged", nack_at, N - 1);
    end else begin
      chk(error && !done, "R8 error without done", {done, error}, 1);
      chk(starts == ((s == 3) ? 2 : 1), "R8 aborted frame starts", starts, (s == 3) ? 2 : 1);
      chk(vcount == 0, "R8 no byte delivered", vcount, 0);
    end
    repeat (60) @(negedge clk);
    chk(done == seen_done && error == !seen_done, "R9 flags held", {done, error}, {seen_done, !seen_done});
    chk(!m_scl_low && !m_sda_low, "R9 lines released after end", {m_scl_low, m_sda_low}, 0);
    chk(vcount == ((s == 0) ? N : 0) && stops == 1, "R9 bus quiet after end", vcount, (s == 0) ? N : 0);
  endtask

  initial begin
    run(0, 37, 11);
    run(0, 91, 200);
    run(1, 37, 11);
    run(2, 37, 11);
    run(3, 37, 11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule